// File: doc/BRIEF.md
# GPIO Bank with Latched Pin Interrupts

This block is a bank of general-purpose pins on a simple register bus. The pin count is a parameter from 1 to 32. Each pin has an output value and a drive-enable bit, so the pin can act as an output or be left as an input. Every pin input goes through a two-flop synchronizer, and software can read the synchronized value.

The same synchronized value feeds a per-pin event detector. Software chooses edge or level detection for each pin, and an active sense: rising edge or high level, or falling edge or low level. Any event that is seen sets a pending bit, and the bit stays set until software writes a 1 to that pin's position in the acknowledge register. A level event stays latched after the level has gone away. Pending bits collect whether or not they are enabled. A single interrupt line is high while any pending bit has its enable bit set.

The bus completes a write on the clock edge where `bus_wr` is high. Read data is combinational from `bus_addr`. Register selects, as word indices on `bus_addr`:
- 0 `REG_OUT`: output values.
- 1 `REG_IN`: synchronized inputs, read-only.
- 2 `REG_DIR`: drive enables, where 1 means drive.
- 3 `REG_PEND`: pending events, read-only.
- 4 `REG_ACK`: write 1 to clear a pending bit; reads as zero.
- 5 `REG_MASK`: interrupt enables.
- 6 `REG_MODE`: 1 means edge, 0 means level.
- 7 `REG_POL`: 1 means rising or high, 0 means falling or low.

Each pin occupies the bit position equal to its pin number.

Top module: `gpio_bank`

## Requirements
- R1: After reset, `pin_out`, `pin_oe`, `REG_OUT`, `REG_DIR`, `REG_MASK` and `REG_PEND` are all zero and `irq_out` is low. `REG_MODE` and `REG_POL` read as ones on every existing pin, which selects rising-edge detection.
- R2: A write to select 0 sets `pin_out`, and a write to select 2 sets `pin_oe` (1 drives). Both take effect after the write edge and read back at the same select.
- R3: Select 1 returns `pin_in` two clock edges after the pin changes: the value is still old after one edge and new after two.
- R4: With the `REG_MODE` bit set to 1, a pin sets its `REG_PEND` bit on a rising edge when its `REG_POL` bit is 1, and on a falling edge when that bit is 0. The opposite transition sets nothing. The pending bit appears three clock edges after the pin changes.
- R5: With the `REG_MODE` bit at 0, a pin whose level equals its `REG_POL` bit sets its `REG_PEND` bit. The bit stays set after the level goes away, even for a one-cycle pulse.
- R6: Writing a mask to select 4 clears exactly the `REG_PEND` bits that are 1 in the mask. Zero bits, including an all-zero write, leave pending bits unchanged.
- R7: When an event and an acknowledge of the same pin fall on the same edge, the pending bit stays set.
- R8: `irq_out` is high exactly when some `REG_PEND` bit and its `REG_MASK` bit are both 1. Pending bits still latch while their `REG_MASK` bit is 0.
- R9: Bits at or above the pin count read as zero at every select, and writes to them are ignored.
- R10: Writes to select 1 and select 3 change nothing, and select 4 always reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register select (word index) |
| bus_wr | input | 1 | Write strobe, taken at the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NUM_PINS | Asynchronous pin inputs |
| pin_out | output | NUM_PINS | Pin output values |
| pin_oe | output | NUM_PINS | Pin drive enables, 1 drives |
| irq_out | output | 1 | Summary interrupt, high while an enabled event is pending |

## Verification
A wrong synchronizer depth shows up when `REG_IN` is read one edge early or late. A wrong previous-value register turns into missing or spurious pending bits three edges after a pin moves. A pending register that loses bits shows at the next read of select 3, and on `irq_out` straight away if the bit is enabled. A wrong set-versus-clear priority shows in the read right after the acknowledge, because a level held active should keep the bit set. A mask mixup shows as `irq_out` following the wrong pin in a one-hot sweep of `REG_MASK`.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int BUS_W  = 32;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_OUT  = 3'd0,
        REG_IN   = 3'd1,
        REG_DIR  = 3'd2,
        REG_PEND = 3'd3,
        REG_ACK  = 3'd4,
        REG_MASK = 3'd5,
        REG_MODE = 3'd6,
        REG_POL  = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= din;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sync_val,
    input  logic [W-1:0] mode_edge,
    input  logic [W-1:0] sense_hi,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] pend
);
    logic [W-1:0] prev_q;
    logic [W-1:0] hit;

    for (genvar i = 0; i < W; i++) begin : g_pin
        logic rise, fall, edge_hit, lvl_hit;
        always_comb begin
            rise     = sync_val[i] & ~prev_q[i];
            fall     = ~sync_val[i] & prev_q[i];
            edge_hit = sense_hi[i] ? rise : fall;
            lvl_hit  = (sync_val[i] == sense_hi[i]);
            hit[i]   = mode_edge[i] ? edge_hit : lvl_hit;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            pend   <= '0;
        end else begin
            prev_q <= sync_val;
            pend   <= (pend & ~clr_mask) | hit;
        end
    end

    assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_mask == '0) |=> ((pend & $past(pend)) == $past(pend)));

    assert_clear_only_target_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(pend) & ~$past(clr_mask) & ~pend) == '0));

    assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (hit != '0) |=> ((pend & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_bank_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    input  logic [W-1:0]      sync_in,
    input  logic [W-1:0]      pend,
    output logic [W-1:0]      out_q,
    output logic [W-1:0]      oe_q,
    output logic [W-1:0]      en_q,
    output logic [W-1:0]      mode_q,
    output logic [W-1:0]      pol_q,
    output logic [W-1:0]      clr_mask
);
    reg_sel_e     sel;
    logic [W-1:0] wpins;
    logic [W-1:0] rd_pins;

    assign sel   = reg_sel_e'(bus_addr);
    assign wpins = bus_wdata[W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q  <= '0;
            oe_q   <= '0;
            en_q   <= '0;
            mode_q <= '1;
            pol_q  <= '1;
        end else if (bus_wr) begin
            case (sel)
                REG_OUT:  out_q  <= wpins;
                REG_DIR:  oe_q   <= wpins;
                REG_MASK: en_q   <= wpins;
                REG_MODE: mode_q <= wpins;
                REG_POL:  pol_q  <= wpins;
                default:  ;
            endcase
        end
    end

    always_comb begin
        clr_mask = '0;
        if (bus_wr && sel == REG_ACK) clr_mask = wpins;
    end

    always_comb begin
        rd_pins = '0;
        unique case (sel)
            REG_OUT:  rd_pins = out_q;
            REG_IN:   rd_pins = sync_in;
            REG_DIR:  rd_pins = oe_q;
            REG_PEND: rd_pins = pend;
            REG_ACK:  rd_pins = '0;
            REG_MASK: rd_pins = en_q;
            REG_MODE: rd_pins = mode_q;
            REG_POL:  rd_pins = pol_q;
        endcase
        bus_rdata           = '0;
        bus_rdata[W-1:0]    = rd_pins;
    end

    assert_pin_regs_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> ($stable(out_q) && $stable(oe_q)));
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS    = 27,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [BUS_W-1:0]    bus_wdata,
    output logic [BUS_W-1:0]    bus_rdata,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                irq_out
);
    logic [NUM_PINS-1:0] sync_val;
    logic [NUM_PINS-1:0] pend;
    logic [NUM_PINS-1:0] en_q;
    logic [NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] clr_mask;

    initial begin
        if (NUM_PINS < 1 || NUM_PINS > BUS_W) $error("NUM_PINS out of range");
    end

    gpio_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pin_in),
        .dout (sync_val)
    );

    gpio_event #(.W(NUM_PINS)) u_event (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_val (sync_val),
        .mode_edge(mode_q),
        .sense_hi (pol_q),
        .clr_mask (clr_mask),
        .pend     (pend)
    );

    gpio_regs #(.W(NUM_PINS)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .sync_in  (sync_val),
        .pend     (pend),
        .out_q    (pin_out),
        .oe_q     (pin_oe),
        .en_q     (en_q),
        .mode_q   (mode_q),
        .pol_q    (pol_q),
        .clr_mask (clr_mask)
    );

    assign irq_out = |(pend & en_q);

    assert_irq_needs_enable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (en_q != '0));
endmodule

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    localparam int NP = 27;
    localparam logic [31:0] PMASK = (NP == 32) ? 32'hFFFF_FFFF : ((32'd1 << NP) - 32'd1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    bus_addr = '0;
    logic          bus_wr = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out;
    logic [NP-1:0] pin_oe;
    logic          irq_out;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_bank #(.NUM_PINS(NP)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic rd_chk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] pat;
        tick(3);
        rst_n = 1'b1;
        tick(2);

        // R1 reset state
        chk("R1 pin_out", 32'(pin_out), 0);
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 irq", 32'(irq_out), 0);
        rd_chk("R1 out", 3'd0, 0);
        rd_chk("R1 dir", 3'd2, 0);
        rd_chk("R1 pend", 3'd3, 0);
        rd_chk("R1 mask", 3'd5, 0);
        rd_chk("R1 mode", 3'd6, PMASK);
        rd_chk("R1 pol", 3'd7, PMASK);

        // R2 / R9 output and direction registers
        for (int k = 0; k < 36; k++) begin
            pat = (k < 32) ? (32'd1 << k) :
                  (k == 32) ? 32'hAAAA_AAAA : (k == 33) ? 32'h5555_5555 :
                  (k == 34) ? 32'hFFFF_FFFF : 32'h0;
            wr(3'd0, pat);
            wr(3'd2, ~pat);
            chk("R2 pin_out", 32'(pin_out), pat & PMASK);
            chk("R2 pin_oe", 32'(pin_oe), ~pat & PMASK);
            rd_chk("R9 out readback", 3'd0, pat & PMASK);
            rd_chk("R9 dir readback", 3'd2, ~pat & PMASK);
        end

        // R3 input synchronizer depth, walking one
        for (int i = 0; i < NP; i++) begin
            pin_in = NP'(1) << i;
            tick(1);
            rd_chk("R3 one edge", 3'd1, 0);
            tick(1);
            rd_chk("R3 two edges", 3'd1, 32'd1 << i);
            pin_in = '0;
            tick(3);
        end
        wr(3'd4, 32'hFFFF_FFFF);
        tick(1);

        // R4 edge detection, both polarities, every pin
        wr(3'd6, 32'hFFFF_FFFF);
        for (int p = 1; p >= 0; p--) begin
            wr(3'd7, p ? 32'hFFFF_FFFF : 32'h0);
            tick(4);
            wr(3'd4, 32'hFFFF_FFFF);
            for (int i = 0; i < NP; i++) begin
                pin_in = NP'(1) << i;
                tick(2);
                rd_chk("R4 before 3 edges", 3'd3, 0);
                tick(1);
                rd_chk("R4 rise", 3'd3, p ? (32'd1 << i) : 32'd0);
                wr(3'd4, 32'hFFFF_FFFF);
                pin_in = '0;
                tick(3);
                rd_chk("R4 fall", 3'd3, p ? 32'd0 : (32'd1 << i));
                wr(3'd4, 32'hFFFF_FFFF);
            end
        end

        // R5 level detection latches one-cycle pulses
        wr(3'd7, 32'hFFFF_FFFF);
        wr(3'd6, 32'h0);
        tick(3);
        wr(3'd4, 32'hFFFF_FFFF);
        for (int i = 0; i < NP; i++) begin
            pin_in = NP'(1) << i;
            tick(1);
            pin_in = '0;
            tick(8);
            rd_chk("R5 level held", 3'd3, 32'd1 << i);
            wr(3'd4, 32'd1 << i);
            rd_chk("R5 cleared", 3'd3, 0);
        end
        // level low
        pin_in = PMASK[NP-1:0];
        wr(3'd7, 32'h0);
        tick(4);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk("R5 low inactive", 3'd3, 0);
        pin_in = '0;
        tick(4);
        rd_chk("R5 low latched", 3'd3, PMASK);

        // R7 set wins against clear while level held active
        wr(3'd4, 32'h0000_0010);
        rd_chk("R7 set wins", 3'd3, PMASK);
        pin_in = PMASK[NP-1:0];
        tick(4);
        wr(3'd4, 32'hFFFF_FFFF);
        rd_chk("R7 released", 3'd3, 0);

        // R6 selective clear in edge mode
        wr(3'd6, 32'hFFFF_FFFF);
        wr(3'd7, 32'h0);
        pat = 32'h0555_5A5A & PMASK;
        pin_in = PMASK[NP-1:0] & ~pat[NP-1:0];
        tick(4);
        rd_chk("R6 set pattern", 3'd3, pat);
        wr(3'd4, 32'h0);
        rd_chk("R6 zero write", 3'd3, pat);
        for (int i = 0; i < NP; i++) begin
            if (pat[i]) begin
                wr(3'd4, 32'd1 << i);
                pat[i] = 1'b0;
                rd_chk("R6 single clear", 3'd3, pat);
            end
        end
        pin_in = PMASK[NP-1:0];
        tick(4);
        wr(3'd4, 32'hFFFF_FFFF);

        // R8 mask sweep with latched events
        pat = 32'h0333_0C0F & PMASK;
        pin_in = PMASK[NP-1:0] & ~pat[NP-1:0];
        tick(4);
        chk("R8 disabled irq low", 32'(irq_out), 0);
        rd_chk("R8 latch while masked", 3'd3, pat);
        for (int i = 0; i < NP; i++) begin
            wr(3'd5, 32'd1 << i);
            chk("R8 irq one-hot", 32'(irq_out), 32'(pat[i]));
        end
        wr(3'd5, 32'hFFFF_FFFF);
        rd_chk("R9 mask readback", 3'd5, PMASK);
        chk("R8 irq all", 32'(irq_out), 1);

        // R10 read-only and write-only registers
        wr(3'd3, 32'h0);
        rd_chk("R10 pend write ignored", 3'd3, pat);
        rd(3'd1, v);
        wr(3'd1, ~v);
        rd_chk("R10 in write ignored", 3'd1, v);
        rd_chk("R10 ack reads zero", 3'd4, 0);
        wr(3'd4, pat);
        chk("R8 irq cleared", 32'(irq_out), 0);
        rd_chk("R10 ack still zero", 3'd4, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule